// File: doc/BRIEF.md
# Single-Cycle 16-Bit Load/Store Processor Core

This block is a small processor core that finishes one instruction on every rising clock edge. It fetches a 16-bit instruction word through an instruction read port, decodes it, reads two operands from a sixteen-entry register file and computes a result in a 16-bit ALU. In the same cycle it either writes the result back, reads or writes a data word through the data-memory port, or picks a new program counter. Both memories sit outside the core and answer reads combinationally within the cycle.

The instruction set has eight operations: add, subtract, bitwise and, bitwise or, word load, word store, branch-if-equal and absolute jump. Every instruction has a 4-bit opcode in bits 15:12 and three 4-bit fields below it, except the jump, which carries a 12-bit field. Register 0 always reads 0 and register 1 always reads 1. Addresses count bytes. Words are little-endian and aligned to even addresses.

Top module: `toy16_core`

## Requirements
- R1: While rst_n is low at a rising edge, the program counter becomes 0 and registers 2 to 15 become 0. During and right after reset, imem_addr is 0.
- R2: Opcodes 0010 (add), 0011 (subtract), 0100 (and) and 0101 (or) write R[bits 3:0] with R[bits 11:8] op R[bits 7:4]. Results wrap modulo 2^16.
- R3: Register 0 always reads 0x0000 and register 1 always reads 0x0001. Any write aimed at either of them is dropped.
- R4: Opcode 0000 loads R[bits 7:4] with the data word at R[bits 11:8] plus the sign-extended offset in bits 3:0.
- R5: Opcode 0001 drives R[bits 7:4] on dmem_wdata and raises dmem_we for that one cycle only. The address is computed as for a load. No register is written.
- R6: Opcode 0111 compares R[bits 11:8] with R[bits 7:4]. If they are equal, the next PC is PC+2 plus twice the sign-extended offset in bits 3:0. Otherwise the next PC is PC+2.
- R7: Opcode 1000 sets the next PC to bits 11:0 times 2, zero-extended.
- R8: Opcodes 0110 and 1001 to 1111 write no register and no memory, and the PC advances by 2.
- R9: imem_addr equals the PC. Every opcode other than 0111 and 1000 advances the PC by 2.
- R10: Operands are read before the write-back of the same instruction lands, so an instruction whose destination is also a source sees the old value.
- R11: Bit 0 of dmem_addr is always 0. An odd effective address is rounded down to the even word address. dmem_we is high only for opcode 0001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 16 | Byte address of the instruction being executed (the PC) |
| imem_data | input | 16 | Instruction word at imem_addr |
| dmem_addr | output | 16 | Word-aligned byte address for load or store |
| dmem_wdata | output | 16 | Store data |
| dmem_rdata | input | 16 | Data word read at dmem_addr |
| dmem_we | output | 1 | Store strobe for the current cycle |

## Verification
Two things can happen in the same cycle: a read of a register and the write-back into that same register. An add whose destination is one of its sources does both, and so does a load whose base register is also its target. The bench provokes this with an instruction that doubles a register in place, then uses the doubled value as a store base address. A second case pairs a store with an odd effective address against the alignment rule. A behavioural reference model is compared with the PC, the store strobe, the address and the store data on every clock. It runs over a directed program and over a long stream of random instruction words, and the final memory images of the two are compared word by word.

// File: rtl/toy16_pkg.sv
// Shared types for the 16-bit single-cycle core: opcode values, ALU
// operations and the decoded control bundle. Assumes fixed 16-bit words.
package toy16_pkg;

    localparam int INSTR_W = 16;
    localparam int OPC_W   = 4;
    localparam int FLD_W   = 4;
    localparam int JFLD_W  = 12;

    typedef enum logic [OPC_W-1:0] {
        OP_LW  = 4'b0000,
        OP_SW  = 4'b0001,
        OP_ADD = 4'b0010,
        OP_SUB = 4'b0011,
        OP_AND = 4'b0100,
        OP_OR  = 4'b0101,
        OP_BEQ = 4'b0111,
        OP_JMP = 4'b1000
    } opcode_e;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR
    } alu_op_e;

    typedef struct packed {
        logic    reg_we;      // write back to the register file
        logic    dst_is_rt;   // destination field is bits 7:4, else 3:0
        logic    use_imm;     // second ALU operand is the offset
        logic    wb_from_mem; // write-back source is load data
        logic    mem_we;      // store strobe
        logic    branch;      // conditional PC-relative transfer
        logic    jump;        // absolute transfer
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/toy16_decode.sv
// Instruction decoder: maps the 4-bit opcode to the control bundle.
// Assumes unlisted opcodes are no-operations (all enables low).
module toy16_decode
    import toy16_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output ctrl_t            ctrl
);

    // Opcode to control lookup; default leaves every enable off.
    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        case (opcode)
            OP_LW: begin
                ctrl.reg_we      = 1'b1;
                ctrl.dst_is_rt   = 1'b1;
                ctrl.use_imm     = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            OP_SW: begin
                ctrl.use_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            OP_ADD: begin
                ctrl.reg_we = 1'b1;
                ctrl.alu_op = ALU_ADD;
            end
            OP_SUB: begin
                ctrl.reg_we = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            OP_AND: begin
                ctrl.reg_we = 1'b1;
                ctrl.alu_op = ALU_AND;
            end
            OP_OR: begin
                ctrl.reg_we = 1'b1;
                ctrl.alu_op = ALU_OR;
            end
            OP_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            OP_JMP: begin
                ctrl.jump = 1'b1;
            end
            default: begin
                ctrl.reg_we = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/toy16_regfile.sv
// Register file with two combinational read ports and one write port.
// Entry 0 is the constant 0 and entry 1 the constant 1; writes to them
// are dropped. Other entries clear on synchronous active-low reset.
module toy16_regfile #(
    parameter int W  = 16,
    parameter int N  = 16,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [N-1:0][W-1:0] bank;

    for (genvar i = 0; i < N; i++) begin : g_entry
        if (i == 0) begin : g_zero
            assign bank[i] = '0;
        end else if (i == 1) begin : g_one
            assign bank[i] = W'(1);
        end else begin : g_store
            logic [W-1:0] q;
            // Hold one general register; load on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (we && wa == AW'(i))
                    q <= wd;
            end
            assign bank[i] = q;
        end
    end

    assign rd1 = bank[ra1];
    assign rd2 = bank[ra2];

endmodule

// File: rtl/toy16_alu.sv
// Arithmetic/logic unit: add, subtract, and, or on W-bit operands with
// wrap-around; flags a zero result for the equality branch.
module toy16_alu
    import toy16_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         zero
);

    // Select the operation result.
    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/toy16_pcgen.sv
// Program counter and next-PC selection: sequential PC+2, PC-relative
// branch from PC+2 with a word-scaled signed offset, or absolute jump
// with a word-scaled field. Assumes the PC stays even.
module toy16_pcgen #(
    parameter int W    = 16,
    parameter int BO_W = 4,
    parameter int JF_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_branch,
    input  logic            take_jump,
    input  logic [BO_W-1:0] br_off,
    input  logic [JF_W-1:0] jmp_field,
    output logic [W-1:0]    pc
);

    localparam int BR_PAD = W - BO_W - 1;
    localparam int JM_PAD = W - JF_W - 1;

    logic [W-1:0] pc_seq;
    logic [W-1:0] br_tgt;
    logic [W-1:0] jmp_tgt;
    logic [W-1:0] pc_next;

    assign pc_seq  = pc + W'(2);
    assign br_tgt  = pc_seq + {{BR_PAD{br_off[BO_W-1]}}, br_off, 1'b0};
    assign jmp_tgt = {{JM_PAD{1'b0}}, jmp_field, 1'b0};

    // Pick the next PC; a jump outranks a branch (never both at once).
    always_comb begin
        if (take_jump)
            pc_next = jmp_tgt;
        else if (take_branch)
            pc_next = br_tgt;
        else
            pc_next = pc_seq;
    end

    // Program counter register, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= '0;
        else
            pc <= pc_next;
    end

endmodule

// File: rtl/toy16_core.sv
// Single-cycle 16-bit core. Fetches, decodes and executes one instruction
// per clock. Assumes both memories answer reads combinationally and that
// data words are aligned (address bit 0 is forced low).
module toy16_core
    import toy16_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NREGS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [DATA_W-1:0] imem_addr,
    input  logic [DATA_W-1:0] imem_data,
    output logic [DATA_W-1:0] dmem_addr,
    output logic [DATA_W-1:0] dmem_wdata,
    input  logic [DATA_W-1:0] dmem_rdata,
    output logic              dmem_we
);

    localparam int RA_W = $clog2(NREGS);

    ctrl_t             ctrl;
    logic [RA_W-1:0]   f_rs;
    logic [RA_W-1:0]   f_rt;
    logic [RA_W-1:0]   f_rd;
    logic [FLD_W-1:0]  f_off;
    logic [DATA_W-1:0] off_ext;
    logic [DATA_W-1:0] rs_val;
    logic [DATA_W-1:0] rt_val;
    logic [DATA_W-1:0] alu_b;
    logic [DATA_W-1:0] alu_y;
    logic              alu_zero;
    logic [RA_W-1:0]   wr_addr;
    logic [DATA_W-1:0] wr_data;

    assign f_rs    = imem_data[11:8];
    assign f_rt    = imem_data[7:4];
    assign f_rd    = imem_data[3:0];
    assign f_off   = imem_data[3:0];
    assign off_ext = {{(DATA_W-FLD_W){f_off[FLD_W-1]}}, f_off};

    toy16_decode u_dec (
        .opcode (imem_data[15:12]),
        .ctrl   (ctrl)
    );

    toy16_regfile #(.W(DATA_W), .N(NREGS)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (f_rs),
        .ra2   (f_rt),
        .rd1   (rs_val),
        .rd2   (rt_val),
        .we    (ctrl.reg_we),
        .wa    (wr_addr),
        .wd    (wr_data)
    );

    assign alu_b = ctrl.use_imm ? off_ext : rt_val;

    toy16_alu #(.W(DATA_W)) u_alu (
        .op   (ctrl.alu_op),
        .a    (rs_val),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign wr_addr = ctrl.dst_is_rt   ? f_rt       : f_rd;
    assign wr_data = ctrl.wb_from_mem ? dmem_rdata : alu_y;

    toy16_pcgen #(.W(DATA_W), .BO_W(FLD_W), .JF_W(JFLD_W)) u_pc (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_branch (ctrl.branch & alu_zero),
        .take_jump   (ctrl.jump),
        .br_off      (f_off),
        .jmp_field   (imem_data[JFLD_W-1:0]),
        .pc          (imem_addr)
    );

    assign dmem_addr  = {alu_y[DATA_W-1:1], 1'b0};
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.mem_we;

endmodule

// File: rtl/toy16_core_chk.sv
// Property checker for toy16_core, attached by bind below. Observes the
// memory ports only.
module toy16_core_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] imem_addr,
    input logic [W-1:0] imem_data,
    input logic [W-1:0] dmem_addr,
    input logic         dmem_we
);

    logic [3:0] opc;
    logic       opc_undef;
    assign opc       = imem_data[15:12];
    assign opc_undef = (opc == 4'b0110) || (opc[3] && opc != 4'b1000);

    AST_RESET_PC: assert property (@(posedge clk)
        !rst_n |=> imem_addr == '0); // R1

    AST_STORE_ONLY_SW: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> opc == 4'b0001); // R11

    AST_STORE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> dmem_addr[0] == 1'b0); // R11

    AST_UNDEF_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        opc_undef |-> !dmem_we); // R8

    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (opc != 4'b0111 && opc != 4'b1000) |=> imem_addr == $past(imem_addr) + W'(2)); // R9

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        opc == 4'b1000 |=> imem_addr == {{(W-13){1'b0}}, $past(imem_data[11:0]), 1'b0}); // R7

    AST_PC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        imem_addr[0] == 1'b0); // R9

endmodule

bind toy16_core toy16_core_chk #(.W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .imem_addr (imem_addr),
    .imem_data (imem_data),
    .dmem_addr (dmem_addr),
    .dmem_we   (dmem_we)
);

// File: tb/toy16_core_test.sv
`timescale 1ns/1ps
module toy16_core_test;

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [15:0] imem    [256];
    logic [15:0] dmem    [256];
    logic [15:0] ref_mem [256];
    logic [15:0] ref_reg [16];
    logic [15:0] ref_pc;
    string       pc_tag;
    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;

    always #2.5 clk = ~clk;

    assign imem_data  = imem[imem_addr[8:1]];
    assign dmem_rdata = dmem[dmem_addr[8:1]];

    toy16_core uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_rdata),
        .dmem_we    (dmem_we)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] rreg(input logic [3:0] i);
        if (i == 4'd0) return 16'h0000;
        if (i == 4'd1) return 16'h0001;
        return ref_reg[i];
    endfunction

    task automatic wreg(input logic [3:0] i, input logic [15:0] v);
        if (i > 4'd1) ref_reg[i] = v;
    endtask

    task automatic init_data();
        for (int i = 0; i < 256; i++) begin
            dmem[i]    = 16'hA000 + 16'(i * 3);
            ref_mem[i] = 16'hA000 + 16'(i * 3);
        end
    endtask

    // Hold reset for a few cycles; R1 reset state is checked at the ports.
    task automatic do_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 16; i++) ref_reg[i] = 16'h0000;
        ref_pc = 16'h0000;
        pc_tag = "R1";
        repeat (3) @(negedge clk);
        check("R1 reset pc", imem_addr, 16'h0000);
        rst_n = 1'b1;
    endtask

    // Compare ports with the model each cycle, then advance both.
    task automatic run_cycles(input int n);
        for (int c = 0; c < n; c++) begin
            logic [15:0] ins, a, b, off, ea;
            logic [3:0]  op;
            ins = imem[ref_pc[8:1]];
            op  = ins[15:12];
            a   = rreg(ins[11:8]);
            b   = rreg(ins[7:4]);
            off = {{12{ins[3]}}, ins[3:0]};
            ea  = (a + off) & 16'hFFFE;
            check({pc_tag, " pc"}, imem_addr, ref_pc);
            check("R5 R11 store strobe", {15'b0, dmem_we}, {15'b0, op == 4'b0001});
            if (op == 4'b0000) check("R4 load address", dmem_addr, ea);
            if (op == 4'b0001) begin
                check("R11 store address", dmem_addr, ea);
                check("R5 store data", dmem_wdata, b);
            end
            if (dmem_we) dmem[dmem_addr[8:1]] = dmem_wdata;
            pc_tag = "R9";
            case (op)
                4'b0010: wreg(ins[3:0], a + b);
                4'b0011: wreg(ins[3:0], a - b);
                4'b0100: wreg(ins[3:0], a & b);
                4'b0101: wreg(ins[3:0], a | b);
                4'b0000: wreg(ins[7:4], ref_mem[ea[8:1]]);
                4'b0001: ref_mem[ea[8:1]] = b;
                default: ;
            endcase
            if (op == 4'b0111) begin
                ref_pc = (a == b) ? ref_pc + 16'd2 + {off[14:0], 1'b0} : ref_pc + 16'd2;
                pc_tag = "R6";
            end else if (op == 4'b1000) begin
                ref_pc = {3'b000, ins[11:0], 1'b0};
                pc_tag = "R7";
            end else begin
                ref_pc = ref_pc + 16'd2;
            end
            @(negedge clk);
        end
    endtask

    task automatic compare_images(input string tag);
        for (int i = 0; i < 256; i++) check(tag, dmem[i], ref_mem[i]);
    endtask

    initial begin
        int seed;
        // Directed program (word index: encoding)
        for (int i = 0; i < 256; i++) imem[i] = 16'h801B;
        imem[0]  = 16'h2112; // R2 = 1+1
        imem[1]  = 16'h2222; // R2 = R2+R2 in place (R10)
        imem[2]  = 16'h3013; // R3 = 0-1 wraps (R2)
        imem[3]  = 16'h2310; // write to R0 dropped (R3)
        imem[4]  = 16'h1200; // store R0 at 4
        imem[5]  = 16'h004F; // R4 = M[0-1 -> 0xFFFE] (R4, R11)
        imem[6]  = 16'h1243; // store R4 at 4+3 -> 6 (R11)
        imem[7]  = 16'h4425; // R5 = R4 & R2
        imem[8]  = 16'h5216; // R6 = R2 | R1
        imem[9]  = 16'h7015; // not taken (R6)
        imem[10] = 16'h7222; // taken to word 13
        imem[11] = 16'h2117;
        imem[12] = 16'h2117;
        imem[13] = 16'h6123; // undefined opcode (R8)
        imem[14] = 16'hF2F7; // undefined opcode (R8)
        imem[15] = 16'h8014; // jump to word 20
        imem[16] = 16'h2117;
        imem[17] = 16'h2117;
        imem[18] = 16'h2117;
        imem[19] = 16'h8016; // jump to word 22
        imem[20] = 16'h2118; // R8 = 2
        imem[21] = 16'h700D; // backward branch to word 19
        imem[22] = 16'h1254; // M[8]  = R5
        imem[23] = 16'h1266; // M[10] = R6
        imem[24] = 16'h1677; // M[12] = R7
        imem[25] = 16'h1080; // M[0]  = R8
        imem[26] = 16'h1032; // M[2]  = R3
        imem[27] = 16'h801B; // halt loop
        init_data();
        do_reset();
        run_cycles(40);
        check("R7 jump path wrote R8", dmem[0], 16'h0002);
        check("R8 undefined kept R3", dmem[1], 16'hFFFF);
        check("R3 R0 reads zero", dmem[2], 16'h0000);
        check("R4 R11 load odd address", dmem[3], 16'hA2FD);
        check("R2 R10 and result", dmem[4], 16'h0004);
        check("R2 or result", dmem[5], 16'h0005);
        check("R6 R1 skipped writes", dmem[6], 16'h0000);
        compare_images("R2 directed image");

        // Random instruction stream
        seed = 32'h1234_5677;
        for (int i = 0; i < 256; i++) begin
            seed = seed * 1103515245 + 12345;
            imem[i] = seed[30:15];
        end
        init_data();
        do_reset();
        run_cycles(3000);
        compare_images("R4 R5 random image");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            $display("FAIL watchdog expired actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
            $finish;
        end
    end

endmodule